// File: doc/BRIEF.md
# Frame and Superframe Sync Flywheel

This block sits behind the symbol slicer of a quaternary line receiver. It looks at each detected symbol and searches for the 9-symbol frame syncword at any offset. Once it has found the syncword twice, one frame apart, it declares frame lock and keeps a flywheel: a symbol counter and a frame counter that predict where the next syncword and the next superframe boundary will fall. Frames are 120 symbols long, and eight frames make one superframe. The first frame of each superframe carries the syncword with every symbol negated. The block uses that frame to find the superframe boundary, and it gives one strobe per superframe.

In lock the block tolerates corrupted syncwords. A millisecond tick times a 480 ms window that runs only while syncwords keep failing, and any good syncword clears it. When the window expires, frame lock is dropped and hunting starts again. If no lock is regained within a further 480 ms, the block raises a request for the transceiver to stop transmitting and go to reset. The block also detects a reversed line pair, because it then sees negated syncwords where plain ones belong. It then negates every symbol it passes on.

Top module: `frame_sync_flywheel`

## Requirements
- R1: After reset, frame_lock, sframe_lock, sf_start, pol_inv, tx_halt_req and sym_out_valid are all low.
- R2: Frame lock is declared only when a syncword match is followed by a second match exactly 120 symbols later. The second check is made at the expected position. If it misses, the block returns to hunting and frame_lock stays low.
- R3: Symbols are coded 2'b11=+3, 2'b10=+1, 2'b01=-1, 2'b00=-3, and negation is the bitwise complement. The syncword is +3 +3 -3 -3 -3 +3 -3 +3 +3 in order of arrival. During acquisition either the syncword or its complement counts as a match.
- R4: In lock, a complemented syncword (relative to the current polarity) that follows a plain one sets sframe_lock. It pulses sf_start for one cycle, in the cycle after the ninth symbol of that syncword. After that, sf_start pulses every 8 frames from the flywheel even if the marker is corrupted.
- R5: In lock, two complemented syncwords in consecutive frames toggle pol_inv and clear sframe_lock. Later syncword classification uses the new polarity.
- R6: In lock, frame_lock drops on the 480th ms_tick counted while the latest syncword check failed. A correct syncword resets that count to zero.
- R7: After frame lock is lost, tx_halt_req rises on the 480th ms_tick without relock. It falls when frame lock is regained.
- R8: sym_out_valid and sym_out follow sym_valid and sym one cycle later. sym_out is complemented when pol_inv is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sym_valid | input | 1 | A new detected symbol is present |
| sym | input | 2 | Detected quaternary symbol |
| ms_tick | input | 1 | One-cycle pulse each millisecond |
| frame_lock | output | 1 | Frame synchronisation held |
| sframe_lock | output | 1 | Superframe boundary known |
| sf_start | output | 1 | One-cycle strobe at each superframe start |
| pol_inv | output | 1 | Line polarity judged reversed |
| tx_halt_req | output | 1 | Request to stop transmitting and enter reset |
| sym_out_valid | output | 1 | Polarity-corrected symbol valid |
| sym_out | output | 2 | Polarity-corrected symbol |

## Verification
The assertions check several rules on every cycle. A superframe strobe appears only with superframe lock, and superframe lock only with frame lock. Frame lock rises only from the verify state and falls only when the loss timer expires. The halt request is never raised while locked, the loss counter stays below its limit, and the corrected symbol path follows its inputs with the right polarity. Other behaviour needs whole symbol sequences, so only the bench scenarios can show it. This covers the exact symbol of each superframe strobe, the flywheel strobe over a corrupted marker, and the polarity flip on reversed input. It also covers the timer clearing on a good syncword between two error bursts, and the exact tick counts at which lock drops and the halt request rises.

// File: rtl/syncfw_pkg.sv
package syncfw_pkg;
    localparam int SW_LEN = 9;
    // bit SW_LEN-1 arrives first; 1 = +3, 0 = -3
    localparam logic [SW_LEN-1:0] SW_PAT = 9'b110001011;

    typedef enum logic [1:0] {
        ST_HUNT   = 2'd0,
        ST_VERIFY = 2'd1,
        ST_LOCK   = 2'd2
    } sync_state_e;
endpackage

// File: rtl/syncfw_window.sv
module syncfw_window
    import syncfw_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       shift,
    input  logic [1:0] sym,
    output logic       hit_true,
    output logic       hit_comp
);
    logic [SW_LEN-1:0][1:0] win_d, win_q;
    logic [SW_LEN-1:0]      eq_true, eq_comp;

    always_comb begin
        win_d = win_q;
        if (shift) win_d = {win_q[SW_LEN-2:0], sym};
    end

    // element 0 is the newest symbol, compared with the last pattern bit
    for (genvar i = 0; i < SW_LEN; i++) begin : g_cmp
        assign eq_true[i] = (win_d[i] == {2{SW_PAT[i]}});
        assign eq_comp[i] = (win_d[i] == {2{~SW_PAT[i]}});
    end

    assign hit_true = shift && (&eq_true);
    assign hit_comp = shift && (&eq_comp);

    always_ff @(posedge clk) begin
        if (!rst_n) win_q <= '0;
        else        win_q <= win_d;
    end
endmodule

// File: rtl/syncfw_loss_timer.sv
module syncfw_loss_timer #(
    parameter int LIMIT = 480
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic clear,
    input  logic tick,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_d, cnt_q;
    logic          at_end;

    assign at_end  = (cnt_q == CW'(LIMIT - 1));
    assign expired = !clear && run && tick && at_end;

    always_comb begin
        cnt_d = cnt_q;
        if (clear)             cnt_d = '0;
        else if (run && tick)  cnt_d = at_end ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CW'(LIMIT));
endmodule

// File: rtl/frame_sync_flywheel.sv
module frame_sync_flywheel
    import syncfw_pkg::*;
#(
    parameter int FRAME_LEN = 120,
    parameter int SF_FRAMES = 8,
    parameter int LOSS_MS   = 480
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sym_valid,
    input  logic [1:0] sym,
    input  logic       ms_tick,
    output logic       frame_lock,
    output logic       sframe_lock,
    output logic       sf_start,
    output logic       pol_inv,
    output logic       tx_halt_req,
    output logic       sym_out_valid,
    output logic [1:0] sym_out
);
    localparam int POS_W = $clog2(FRAME_LEN);
    localparam int IDX_W = (SF_FRAMES > 1) ? $clog2(SF_FRAMES) : 1;

    typedef struct packed {
        sync_state_e      st;
        logic [POS_W-1:0] pos;
        logic [IDX_W-1:0] idx;
        logic             prev_c;
        logic             sf_lock;
        logic             sf_pulse;
        logic             pol;
        logic             err;
        logic             lost;
        logic             req;
        logic             ov;
        logic [1:0]       osym;
    } regs_t;

    regs_t regs_d, regs_q;

    logic             hit_true, hit_comp, any_hit, rel_c;
    logic [POS_W-1:0] pos_inc;
    logic             chk, good_chk;
    logic             timer_run, timer_clear, timer_expired;

    syncfw_window u_window (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift    (sym_valid),
        .sym      (sym),
        .hit_true (hit_true),
        .hit_comp (hit_comp)
    );

    syncfw_loss_timer #(.LIMIT(LOSS_MS)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (timer_run),
        .clear   (timer_clear),
        .tick    (ms_tick),
        .expired (timer_expired)
    );

    assign any_hit     = hit_true || hit_comp;
    assign rel_c       = regs_q.pol ? hit_true : hit_comp;
    assign pos_inc     = (regs_q.pos == POS_W'(FRAME_LEN - 1)) ? '0 : regs_q.pos + 1'b1;
    assign chk         = sym_valid && (pos_inc == POS_W'(SW_LEN - 1));
    assign good_chk    = chk && any_hit && (regs_q.st != ST_HUNT);
    assign timer_clear = good_chk;
    assign timer_run   = (regs_q.st == ST_LOCK) ? regs_q.err
                                                : (regs_q.lost && !regs_q.req);

    always_comb begin
        regs_d          = regs_q;
        regs_d.sf_pulse = 1'b0;
        regs_d.ov       = sym_valid;
        regs_d.osym     = sym ^ {2{regs_q.pol}};
        if (sym_valid) regs_d.pos = pos_inc;

        unique case (regs_q.st)
            ST_HUNT: begin
                if (any_hit) begin
                    regs_d.st     = ST_VERIFY;
                    regs_d.pos    = POS_W'(SW_LEN - 1);
                    regs_d.prev_c = rel_c;
                end
            end
            ST_VERIFY: begin
                if (chk) begin
                    if (any_hit) begin
                        regs_d.st   = ST_LOCK;
                        regs_d.lost = 1'b0;
                        regs_d.req  = 1'b0;
                        regs_d.err  = 1'b0;
                    end else begin
                        regs_d.st = ST_HUNT;
                    end
                end
            end
            default: ;
        endcase

        if (good_chk) begin
            regs_d.err = 1'b0;
            if (rel_c && regs_q.prev_c) begin
                regs_d.pol     = ~regs_q.pol;
                regs_d.sf_lock = 1'b0;
                regs_d.prev_c  = 1'b0;
            end else if (rel_c) begin
                regs_d.sf_lock  = 1'b1;
                regs_d.idx      = '0;
                regs_d.sf_pulse = 1'b1;
                regs_d.prev_c   = 1'b1;
            end else begin
                regs_d.prev_c = 1'b0;
                if (regs_q.sf_lock) begin
                    regs_d.idx = (regs_q.idx == IDX_W'(SF_FRAMES - 1)) ? '0 : regs_q.idx + 1'b1;
                    regs_d.sf_pulse = (regs_q.idx == IDX_W'(SF_FRAMES - 1));
                end
            end
        end else if (chk && regs_q.st == ST_LOCK) begin
            regs_d.err    = 1'b1;
            regs_d.prev_c = 1'b0;
            if (regs_q.sf_lock) begin
                regs_d.idx = (regs_q.idx == IDX_W'(SF_FRAMES - 1)) ? '0 : regs_q.idx + 1'b1;
                regs_d.sf_pulse = (regs_q.idx == IDX_W'(SF_FRAMES - 1));
            end
        end

        if (timer_expired) begin
            if (regs_q.st == ST_LOCK) begin
                regs_d.st       = ST_HUNT;
                regs_d.sf_lock  = 1'b0;
                regs_d.sf_pulse = 1'b0;
                regs_d.err      = 1'b0;
                regs_d.lost     = 1'b1;
            end else begin
                regs_d.req = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q    <= '0;
            regs_q.st <= ST_HUNT;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign frame_lock    = (regs_q.st == ST_LOCK);
    assign sframe_lock   = regs_q.sf_lock;
    assign sf_start      = regs_q.sf_pulse;
    assign pol_inv       = regs_q.pol;
    assign tx_halt_req   = regs_q.req;
    assign sym_out_valid = regs_q.ov;
    assign sym_out       = regs_q.osym;

    assert_sflock_needs_lock_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sframe_lock |-> frame_lock);

    assert_sfstart_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sf_start |-> sframe_lock);

    assert_lock_via_verify_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_lock) |-> $past(regs_q.st == ST_VERIFY));

    assert_drop_on_expiry_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(frame_lock) |-> $past(timer_expired));

    assert_halt_unlocked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_halt_req |-> !frame_lock);

    assert_out_path_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sym_out_valid |-> (sym_out == ($past(sym) ^ {2{$past(pol_inv)}})));
endmodule

// File: tb/frame_sync_flywheel_tb_top.sv
module frame_sync_flywheel_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sym_valid = 1'b0;
    logic [1:0] sym = 2'b00;
    logic       ms_tick = 1'b0;
    logic       frame_lock, sframe_lock, sf_start, pol_inv, tx_halt_req;
    logic       sym_out_valid;
    logic [1:0] sym_out;

    localparam logic [8:0] PAT = 9'b110001011;
    localparam int FLEN = 120;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  line_inv = 1'b0;
    int  sf_hits;
    int  sf_at;

    always #5 clk = ~clk;

    frame_sync_flywheel dut_i (
        .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid), .sym(sym),
        .ms_tick(ms_tick), .frame_lock(frame_lock), .sframe_lock(sframe_lock),
        .sf_start(sf_start), .pol_inv(pol_inv), .tx_halt_req(tx_halt_req),
        .sym_out_valid(sym_out_valid), .sym_out(sym_out)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; sym_valid = 1'b0; ms_tick = 1'b0; line_inv = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    task automatic send_sym(input logic [1:0] s, input int idx);
        sym_valid = 1'b1;
        sym = s ^ {2{line_inv}};
        @(posedge clk);
        #1;
        sym_valid = 1'b0;
        if (sf_start) begin sf_hits++; sf_at = idx; end
    endtask

    // kind 0 plain syncword, 1 negated marker, 2 corrupted syncword
    task automatic send_frame(input int kind);
        sf_hits = 0; sf_at = -1;
        for (int k = 0; k < 9; k++) begin
            logic b;
            b = PAT[8-k];
            if (kind == 0)      send_sym({2{b}}, k);
            else if (kind == 1) send_sym({2{~b}}, k);
            else                send_sym(2'b01, k);
        end
        for (int k = 9; k < FLEN; k++) send_sym(2'b10, k);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            ms_tick = 1'b1;
            @(posedge clk);
            #1 ms_tick = 1'b0;
        end
    endtask

    task automatic test_reset();
        do_reset();
        check({frame_lock, sframe_lock, sf_start, pol_inv, tx_halt_req, sym_out_valid} == 6'b0,
              "R1 outputs low after reset",
              {frame_lock, sframe_lock, sf_start, pol_inv, tx_halt_req, sym_out_valid}, 0);
    endtask

    task automatic test_acquire();
        do_reset();
        send_frame(1);
        check(frame_lock == 1'b0, "R2 no lock after one syncword", frame_lock, 0);
        send_frame(0);
        check(frame_lock == 1'b1, "R3 lock with complement then plain syncword", frame_lock, 1);
        do_reset();
        send_frame(0);
        send_frame(2);
        check(frame_lock == 1'b0, "R2 miss at expected spacing stays unlocked", frame_lock, 0);
        send_frame(0);
        send_frame(0);
        check(frame_lock == 1'b1, "R2 relock after two spaced syncwords", frame_lock, 1);
    endtask

    task automatic test_superframe();
        int total;
        do_reset();
        send_frame(0); send_frame(0); send_frame(0);
        check(sframe_lock == 1'b0, "R4 no superframe lock before marker", sframe_lock, 0);
        send_frame(1);
        check(sf_hits == 1 && sf_at == 8, "R4 strobe after ninth marker symbol", sf_at, 8);
        check(sframe_lock == 1'b1, "R4 superframe lock after marker", sframe_lock, 1);
        total = 0;
        for (int f = 0; f < 7; f++) begin send_frame(0); total += sf_hits; end
        check(total == 0, "R4 no strobe inside superframe", total, 0);
        send_frame(2);
        check(sf_hits == 1 && sf_at == 8, "R4 flywheel strobe over corrupted marker", sf_at, 8);
    endtask

    task automatic test_polarity();
        do_reset();
        send_sym(2'b10, 0);
        check(sym_out_valid == 1'b1 && sym_out == 2'b10, "R8 symbol passed unchanged", sym_out, 2);
        do_reset();
        line_inv = 1'b1;
        send_frame(1); send_frame(0); send_frame(0);
        check(pol_inv == 1'b1, "R5 reversed line detected", pol_inv, 1);
        check(sframe_lock == 1'b0, "R5 superframe lock cleared on flip", sframe_lock, 0);
        for (int f = 0; f < 5; f++) send_frame(0);
        send_frame(1);
        check(sf_hits == 1 && sf_at == 8, "R5 marker found under new polarity", sf_at, 8);
        send_sym(2'b11, 0);
        check(sym_out == 2'b11, "R8 symbol corrected for reversed line", sym_out, 3);
    endtask

    task automatic test_loss();
        do_reset();
        send_frame(0); send_frame(0);
        send_frame(2);
        ticks(300);
        send_frame(0);
        send_frame(2);
        ticks(300);
        check(frame_lock == 1'b1, "R6 good syncword cleared the loss timer", frame_lock, 1);
        ticks(179);
        check(frame_lock == 1'b1, "R6 lock held at 479 ticks", frame_lock, 1);
        ticks(1);
        check(frame_lock == 1'b0, "R6 lock dropped at 480 ticks", frame_lock, 0);
        ticks(479);
        check(tx_halt_req == 1'b0, "R7 no halt at 479 ticks unlocked", tx_halt_req, 0);
        ticks(1);
        check(tx_halt_req == 1'b1, "R7 halt at 480 ticks unlocked", tx_halt_req, 1);
        send_frame(0); send_frame(0);
        check(frame_lock == 1'b1 && tx_halt_req == 1'b0, "R7 halt cleared on relock",
              tx_halt_req, 0);
    endtask

    initial begin
        #1500000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        test_reset();
        test_acquire();
        test_superframe();
        test_polarity();
        test_loss();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule